// File: doc/BRIEF.md
# Parallel EEPROM Page Write Controller

This block is the device-side write engine of a byte-wide parallel EEPROM with an SRAM-style bus of three active-low strobes (chip select, write strobe, output strobe). A write happens only while chip select and the write strobe are both low and the output strobe is high. A filter rejects strobe pulses that are too short. Each accepted write puts one byte into a 64-byte page buffer and marks that byte as loaded. The first accepted byte fixes the page. Later bytes for the same page may come in any order and may overwrite each other. A load window timer starts again on every accepted byte. When it expires, the page closes and a programming period of fixed length begins. `busy` is high for that whole period. At its end, only the marked bytes are copied into the storage array.

A power-on lockout blocks all writes until the supply-good input has been high for a set number of cycles. The lockout starts over whenever supply-good drops. Reads work as on an SRAM, with one cycle of latency. All durations are parameters in clock cycles, so a short simulation can use small values.

Top module: `eep_page_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `dout` is 0 and every array byte reads 8'hFF. No write is accepted until `pwr_ok` has been high for POR_CYC consecutive clock samples.
- R2: When `ce_n`=0, `oe_n`=0 and `we_n`=1 are sampled at a clock edge, `dout` after that edge holds the array byte at `addr`. In every other case `dout` is 0 after the edge.
- R3: A write strobe is active only while `ce_n`=0, `we_n`=0 and `oe_n`=1 all hold together. A strobe that lasts fewer than FILT_CYC consecutive samples, or that is never active because `oe_n` is low, loads nothing.
- R4: The address is taken in the first sampled cycle of a strobe. The data is taken in its last sampled cycle. The load counts at the first edge where the strobe is no longer active.
- R5: `addr[5:0]` selects the byte within the page and the bits above select the page. While a page is open, a load whose page differs from the open page is ignored and leaves the open page unchanged.
- R6: The programming period starts (`busy` rises) exactly WIN_CYC clock edges after the edge that accepted the last load, provided no further load arrives.
- R7: `busy` stays high for exactly PROG_CYC cycles. Loads during that time are ignored. Reads during it return the old array contents. The new data is visible once `busy` has fallen.
- R8: Only bytes that were loaded into the page change. If a byte is loaded more than once, its last value is kept. Load order does not matter.
- R9: A drop of `pwr_ok` restarts the lockout, so a write issued right after supply-good comes back is ignored and starts no programming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_ok | input | 1 | Supply-good indication |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output strobe, active low |
| addr | input | PAGE_BITS+6 | Byte address: page in the upper bits, byte offset in the low 6 |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Registered read data, 0 when no read is in progress |
| busy | output | 1 | High during the internal programming period |

## Verification
The page is loaded with a mix of operations: bytes out of order, a repeated byte, a byte aimed at another page, a pulse one cycle too short, an attempt with the output strobe low, and a strobe whose address and data change partway through. Reading the page back separates correct masking and last-value-wins behaviour from filtering or page-match errors. A lone load measures the exact gap from acceptance to `busy` and the length of `busy`. Writes issued before the power-on delay ends, and again after a supply drop, show whether the lockout holds. A reference model steps with the design every clock and compares `busy` and `dout`.

// File: rtl/eep_pkg.sv
`timescale 1ns/1ps
package eep_pkg;
    localparam int OFS_W      = 6;
    localparam int PAGE_BYTES = 1 << OFS_W;

    typedef enum logic [1:0] {
        PG_IDLE = 2'd0,
        PG_LOAD = 2'd1,
        PG_PROG = 2'd2
    } pg_state_e;
endpackage

// File: rtl/eep_strobe_filt.sv
`timescale 1ns/1ps
module eep_strobe_filt #(
    parameter int AW       = 9,
    parameter int DW       = 8,
    parameter int FILT_CYC = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          act,
    output logic          fire,
    output logic [AW-1:0] fire_addr,
    output logic [DW-1:0] fire_data
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(FILT_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } filt_t;

    filt_t f_d, f_q;

    always_comb begin
        act  = !ce_n && !we_n && oe_n;
        fire = !act && (f_q.cnt == CNT_MAX);
        f_d  = f_q;
        if (act) begin
            if (f_q.cnt == '0) begin
                f_d.addr = addr;
            end
            f_d.data = din;
            if (f_q.cnt != CNT_MAX) begin
                f_d.cnt = f_q.cnt + 1'b1;
            end
        end else begin
            f_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign fire_addr = f_q.addr;
    assign fire_data = f_q.data;
endmodule

// File: rtl/eep_por_gate.sv
`timescale 1ns/1ps
module eep_por_gate #(
    parameter int POR_CYC = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    output logic ready
);
    localparam int PW = $clog2(POR_CYC + 1);
    localparam logic [PW-1:0] POR_MAX = PW'(POR_CYC);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!pwr_ok) begin
            cnt_d = '0;
        end else if (cnt_q != POR_MAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign ready = (cnt_q == POR_MAX);
endmodule

// File: rtl/eep_array.sv
`timescale 1ns/1ps
module eep_array
    import eep_pkg::*;
#(
    parameter int PAGE_BITS = 3,
    parameter int DW        = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_en,
    input  logic [PAGE_BITS+OFS_W-1:0]     rd_addr,
    input  logic                           commit,
    input  logic [PAGE_BITS-1:0]           cm_page,
    input  logic [PAGE_BYTES-1:0]          cm_mask,
    input  logic [PAGE_BYTES-1:0][DW-1:0]  cm_data,
    output logic [DW-1:0]                  dout
);
    localparam int NBYTES = PAGE_BYTES << PAGE_BITS;

    logic [DW-1:0] mem_d [NBYTES];
    logic [DW-1:0] mem_q [NBYTES];
    logic [DW-1:0] dout_d, dout_q;

    always_comb begin
        for (int i = 0; i < NBYTES; i++) begin
            mem_d[i] = mem_q[i];
        end
        for (int b = 0; b < PAGE_BYTES; b++) begin
            if (commit && cm_mask[b]) begin
                mem_d[{cm_page, OFS_W'(b)}] = cm_data[b];
            end
        end
        dout_d = rd_en ? mem_q[rd_addr] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTES; i++) begin
                mem_q[i] <= '1;
            end
            dout_q <= '0;
        end else begin
            for (int i = 0; i < NBYTES; i++) begin
                mem_q[i] <= mem_d[i];
            end
            dout_q <= dout_d;
        end
    end

    assign dout = dout_q;
endmodule

// File: rtl/eep_page_ctrl.sv
`timescale 1ns/1ps
module eep_page_ctrl
    import eep_pkg::*;
#(
    parameter int PAGE_BITS = 3,
    parameter int DATA_W    = 8,
    parameter int FILT_CYC  = 3,
    parameter int WIN_CYC   = 30000,
    parameter int POR_CYC   = 1000000,
    parameter int PROG_CYC  = 2000000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pwr_ok,
    input  logic                          ce_n,
    input  logic                          we_n,
    input  logic                          oe_n,
    input  logic [PAGE_BITS+OFS_W-1:0]    addr,
    input  logic [DATA_W-1:0]             din,
    output logic [DATA_W-1:0]             dout,
    output logic                          busy
);
    localparam int AW  = PAGE_BITS + OFS_W;
    localparam int WW  = $clog2(WIN_CYC + 1);
    localparam int PRW = $clog2(PROG_CYC + 1);
    localparam logic [WW-1:0]  WIN_LAST  = WW'(WIN_CYC - 1);
    localparam logic [PRW-1:0] PROG_LAST = PRW'(PROG_CYC - 1);

    typedef struct packed {
        pg_state_e                              state;
        logic [PAGE_BITS-1:0]                   page;
        logic [WW-1:0]                          win_cnt;
        logic [PRW-1:0]                         prog_cnt;
        logic [PAGE_BYTES-1:0]                  mask;
        logic [PAGE_BYTES-1:0][DATA_W-1:0]      pbuf;
    } ctl_t;

    ctl_t s_d, s_q;

    logic              act;
    logic              fire;
    logic [AW-1:0]     ld_addr;
    logic [DATA_W-1:0] ld_data;
    logic              ready;
    logic              accept;
    logic              commit;
    logic              rd_en;
    logic [PAGE_BITS-1:0] ld_page;
    logic [OFS_W-1:0]     ld_ofs;

    eep_strobe_filt #(
        .AW       (AW),
        .DW       (DATA_W),
        .FILT_CYC (FILT_CYC)
    ) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .addr      (addr),
        .din       (din),
        .act       (act),
        .fire      (fire),
        .fire_addr (ld_addr),
        .fire_data (ld_data)
    );

    eep_por_gate #(
        .POR_CYC (POR_CYC)
    ) u_por (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwr_ok (pwr_ok),
        .ready  (ready)
    );

    always_comb begin
        ld_page = ld_addr[AW-1:OFS_W];
        ld_ofs  = ld_addr[OFS_W-1:0];
        rd_en   = !ce_n && !oe_n && we_n;
        accept  = fire && ready && (s_q.state != PG_PROG) &&
                  ((s_q.state == PG_IDLE) || (ld_page == s_q.page));
        commit  = (s_q.state == PG_PROG) && (s_q.prog_cnt == PROG_LAST);

        s_d = s_q;
        unique case (s_q.state)
            PG_IDLE: begin
                if (accept) begin
                    s_d.state        = PG_LOAD;
                    s_d.page         = ld_page;
                    s_d.win_cnt      = '0;
                    s_d.mask         = '0;
                    s_d.mask[ld_ofs] = 1'b1;
                    s_d.pbuf[ld_ofs] = ld_data;
                end
            end
            PG_LOAD: begin
                if (accept) begin
                    s_d.win_cnt      = '0;
                    s_d.mask[ld_ofs] = 1'b1;
                    s_d.pbuf[ld_ofs] = ld_data;
                end else if (s_q.win_cnt == WIN_LAST) begin
                    s_d.state    = PG_PROG;
                    s_d.prog_cnt = '0;
                end else begin
                    s_d.win_cnt = s_q.win_cnt + 1'b1;
                end
            end
            PG_PROG: begin
                if (commit) begin
                    s_d.state = PG_IDLE;
                    s_d.mask  = '0;
                end else begin
                    s_d.prog_cnt = s_q.prog_cnt + 1'b1;
                end
            end
            default: begin
                s_d.state = PG_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= PG_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    eep_array #(
        .PAGE_BITS (PAGE_BITS),
        .DW        (DATA_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (addr),
        .commit  (commit),
        .cm_page (s_q.page),
        .cm_mask (s_q.mask),
        .cm_data (s_q.pbuf),
        .dout    (dout)
    );

    assign busy = (s_q.state == PG_PROG);
endmodule

// File: rtl/eep_page_ctrl_chk.sv
`timescale 1ns/1ps
module eep_page_ctrl_chk #(
    parameter int PAGE_BITS = 3,
    parameter int DATA_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ce_n,
    input logic                 we_n,
    input logic                 oe_n,
    input logic                 busy,
    input logic [DATA_W-1:0]    dout,
    input logic                 ready,
    input logic                 act,
    input logic                 fire,
    input logic                 accept,
    input logic [1:0]           state,
    input logic [PAGE_BITS-1:0] page_q,
    input logic [PAGE_BITS-1:0] ld_page
);
    a_r1_locked_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !accept);

    a_r7_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !accept);

    a_r5_same_page: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd1 && accept) |-> (ld_page == page_q));

    a_r4_fire_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (!act && $past(act)));

    a_r6_prog_from_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(state) == 2'd1));

    a_r2_idle_dout_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ce_n && !oe_n && we_n) |=> (dout == '0));
endmodule

bind eep_page_ctrl eep_page_ctrl_chk #(
    .PAGE_BITS (PAGE_BITS),
    .DATA_W    (DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .busy    (busy),
    .dout    (dout),
    .ready   (ready),
    .act     (act),
    .fire    (fire),
    .accept  (accept),
    .state   (s_q.state),
    .page_q  (s_q.page),
    .ld_page (ld_page)
);

// File: tb/sim_eep_page_ctrl.sv
`timescale 1ns/1ps
module sim_eep_page_ctrl;
    localparam int PB   = 3;
    localparam int AW   = PB + 6;
    localparam int FILT = 3;
    localparam int WIN  = 20;
    localparam int POR  = 50;
    localparam int PROG = 40;
    localparam int NB   = 64 << PB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_ok = 1'b0;
    logic          ce_n = 1'b1;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic          busy;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    eep_page_ctrl #(
        .PAGE_BITS (PB),
        .DATA_W    (8),
        .FILT_CYC  (FILT),
        .WIN_CYC   (WIN),
        .POR_CYC   (POR),
        .PROG_CYC  (PROG)
    ) u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwr_ok (pwr_ok),
        .ce_n   (ce_n),
        .we_n   (we_n),
        .oe_n   (oe_n),
        .addr   (addr),
        .din    (din),
        .dout   (dout),
        .busy   (busy)
    );

    // behavioural reference model
    byte unsigned m_mem [NB];
    byte unsigned m_buf [64];
    bit           m_msk [64];
    int           m_act = 0;
    int           m_caddr = 0;
    byte unsigned m_cdat = 0;
    int           m_mode = 0;      // 0 idle, 1 loading, 2 programming
    int           m_page = 0;
    int           m_tmr = 0;
    int           m_pc = 0;
    int           m_por = 0;
    byte unsigned m_dout = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 8'hFF;
            foreach (m_msk[i]) m_msk[i] = 0;
            m_act = 0; m_mode = 0; m_tmr = 0; m_pc = 0; m_por = 0; m_dout = 0;
        end else begin
            bit act_now, fire, ok;
            act_now = !ce_n && !we_n && oe_n;
            fire = (m_act >= FILT) && !act_now;
            ok = fire && (m_por == POR) && (m_mode != 2) &&
                 (m_mode == 0 || (m_caddr >> 6) == m_page);
            m_dout = (!ce_n && !oe_n && we_n) ? m_mem[int'(addr)] : 8'h00;
            if (m_mode == 0) begin
                if (ok) begin
                    foreach (m_msk[i]) m_msk[i] = 0;
                    m_page = m_caddr >> 6;
                    m_buf[m_caddr % 64] = m_cdat;
                    m_msk[m_caddr % 64] = 1;
                    m_tmr = 0; m_mode = 1;
                end
            end else if (m_mode == 1) begin
                if (ok) begin
                    m_buf[m_caddr % 64] = m_cdat;
                    m_msk[m_caddr % 64] = 1;
                    m_tmr = 0;
                end else if (m_tmr == WIN - 1) begin
                    m_mode = 2; m_pc = 0;
                end else begin
                    m_tmr++;
                end
            end else begin
                if (m_pc == PROG - 1) begin
                    for (int i = 0; i < 64; i++)
                        if (m_msk[i]) m_mem[m_page * 64 + i] = m_buf[i];
                    m_mode = 0;
                end else begin
                    m_pc++;
                end
            end
            if (act_now) begin
                if (m_act == 0) m_caddr = int'(addr);
                m_cdat = din;
                if (m_act < FILT) m_act++;
            end else begin
                m_act = 0;
            end
            if (!pwr_ok) m_por = 0;
            else if (m_por < POR) m_por++;
        end
    end

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            total++;
            if (busy !== (m_mode == 2)) begin
                bad++;
                $display("FAIL R7 busy cyc=%0d actual=%0b expected=%0b", cyc, busy, m_mode == 2);
            end
            total++;
            if (dout !== m_dout) begin
                bad++;
                $display("FAIL R2 dout cyc=%0d actual=%02h expected=%02h", cyc, dout, m_dout);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act_v, input int exp_v);
        total++;
        if (act_v != exp_v) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
        end
    endtask

    task automatic wr(input int a, input int d, input int n, input bit oe_v);
        addr = AW'(a); din = 8'(d); ce_n = 0; we_n = 0; oe_n = oe_v;
        repeat (n) @(negedge clk);
        ce_n = 1; we_n = 1; oe_n = 1;
        @(negedge clk);
    endtask

    task automatic wr_split(input int a1, input int d1, input int a2, input int d2, input int n);
        addr = AW'(a1); din = 8'(d1); ce_n = 0; we_n = 0; oe_n = 1;
        @(negedge clk);
        addr = AW'(a2); din = 8'(d2);
        repeat (n - 1) @(negedge clk);
        ce_n = 1; we_n = 1;
        @(negedge clk);
    endtask

    task automatic rd(input int a, input int exp_v, input string tag);
        addr = AW'(a); ce_n = 0; oe_n = 0; we_n = 1;
        @(negedge clk);
        chk(tag, dout, exp_v);
        ce_n = 1; oe_n = 1;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int k;
        int n;
        repeat (3) @(negedge clk);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset dout", dout, 0);
        rst_n = 1;
        @(negedge clk);
        pwr_ok = 1;
        @(negedge clk);
        // R1: write during lockout ignored
        wr(9'h040, 8'h11, FILT, 1);
        repeat (WIN + 5) @(negedge clk);
        chk("R1 no prog in lockout", busy, 0);
        repeat (POR) @(negedge clk);
        rd(9'h040, 8'hFF, "R1 locked write ignored");

        // page 2 mixed load
        wr(9'h085, 8'h21, FILT, 1);
        wr(9'h080, 8'h22, FILT, 1);
        wr(9'h0BF, 8'h23, FILT + 2, 1);
        wr(9'h0C7, 8'h99, FILT, 1);          // R5 other page
        wr(9'h085, 8'h24, FILT, 1);          // R8 rewrite
        wr(9'h089, 8'h55, FILT - 1, 1);      // R3 short pulse
        wr(9'h08A, 8'h66, FILT + 1, 0);      // R3 oe low
        wr_split(9'h08B, 8'h30, 9'h08C, 8'h31, FILT + 1); // R4
        k = 0;
        while (!busy && k < 500) begin @(negedge clk); k++; end
        chk("R6 busy reached", busy, 1);
        rd(9'h085, 8'hFF, "R7 read during busy old data");
        wr(9'h094, 8'h77, FILT, 1);          // R7 ignored load
        wait_idle();
        repeat (WIN + 5) @(negedge clk);
        chk("R7 busy load started nothing", busy, 0);
        rd(9'h085, 8'h24, "R8 last value wins");
        rd(9'h080, 8'h22, "R8 any order");
        rd(9'h0BF, 8'h23, "R8 top byte");
        rd(9'h081, 8'hFF, "R8 unloaded byte kept");
        rd(9'h0C7, 8'hFF, "R5 other page ignored");
        rd(9'h089, 8'hFF, "R3 short pulse ignored");
        rd(9'h08A, 8'hFF, "R3 oe low ignored");
        rd(9'h08B, 8'h31, "R4 addr first data last");
        rd(9'h08C, 8'hFF, "R4 later addr unused");
        rd(9'h094, 8'hFF, "R7 load during busy ignored");

        // R6 window and R7 length
        wr(9'h101, 8'h5A, FILT, 1);
        k = 1;
        while (!busy && k < 500) begin @(negedge clk); k++; end
        chk("R6 window cycles", k, WIN + 1);
        n = 0;
        while (busy && n < 500) begin n++; @(negedge clk); end
        chk("R7 busy length", n, PROG);
        @(negedge clk);
        rd(9'h101, 8'h5A, "R7 data after busy");

        // R9 supply drop restarts lockout
        pwr_ok = 0;
        @(negedge clk);
        pwr_ok = 1;
        wr(9'h140, 8'h42, FILT, 1);
        repeat (WIN + PROG + 10) @(negedge clk);
        chk("R9 no prog after drop", busy, 0);
        rd(9'h140, 8'hFF, "R9 write after drop ignored");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule